// File: doc/BRIEF.md
# Oversampled SPI Slave Shifter

This block is a serial-peripheral slave that lives entirely in a fast system clock domain. The serial clock, the master's data line and the active-low select arrive asynchronously. Each passes through a two-flop synchroniser, and serial-clock edges are found by comparing consecutive synchronised samples. The master's serial clock period must span at least eight system clocks, with each high and low phase lasting at least four.

Software loads the next outgoing word through a one-word write port and reads the last complete incoming word from a parallel output. A one-cycle pulse marks each finished word. A flag shows when the loaded word has been taken for shifting, so the next word may be written. Clock polarity, clock phase and bit order are static configuration inputs, changed only while the select is inactive. After the final bit of a word, the slave keeps that bit on its data output until a new word is written. A word the master clocks without a prior write therefore repeats that final bit in every position.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, `rd_data` is 0, `rx_done` is 0, `tx_empty` is 1 and `miso_oe` is 0 while `csn_in` is high.
- R2: The transmit edge and the receive edge depend on polarity and phase. With `cpol`=0 and `cpha`=0, the output advances on the serial-clock rise and input is taken on the fall. Setting `cpha`=1 swaps these two edges. Setting `cpol`=1 inverts both edges. All four combinations transfer words correctly in both directions.
- R3: With `lsb_first`=1, bit 0 of a word is the first bit shifted out and the first bit received. With `lsb_first`=0, bit WORD_W-1 comes first. The same setting governs both directions.
- R4: A word written while no word is in progress drives its first bit onto `miso_out` one system clock after the write cycle, before any serial-clock edge.
- R5: Within a word, `miso_out` changes only in response to a transmit edge. It stays stable across the following receive edge.
- R6: After the last bit of a word, `miso_out` holds that bit until the next write. A word clocked by the master with no intervening write sends that held bit in every position.
- R7: After the WORD_W-th receive edge of a word, `rd_data` takes the received word and `rx_done` pulses high for exactly one system clock.
- R8: `tx_empty` falls the cycle after a write. It rises again when the first receive edge of a word loads the written word for shifting.
- R9: Raising `csn_in` drops `miso_oe` and clears the bit count without signalling completion. The next select starts a fresh word from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: transmit on leading edge, 1: transmit on trailing edge |
| lsb_first | input | 1 | Bit order for both directions |
| sclk_in | input | 1 | Serial clock from master (asynchronous) |
| mosi_in | input | 1 | Serial data from master (asynchronous) |
| csn_in | input | 1 | Active-low slave select (asynchronous) |
| wr_en | input | 1 | Write strobe for the next transmit word |
| wr_data | input | WORD_W | Next transmit word |
| rd_data | output | WORD_W | Last complete received word |
| rx_done | output | 1 | One-cycle pulse when a word completes |
| tx_empty | output | 1 | High when the transmit buffer may be written |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso_out |

## Verification
A bit counter that slips by one shows up at the ports within the word that caused it. `rx_done` arrives early or late against the master's edge count, and `rd_data` carries a rotated word. An off-by-one in the transmit shifter is visible half a serial period after the faulty edge, because the master model samples `miso_out` at every receive edge. A lost or doubled buffer-full state shows on `tx_empty` one clock after the write or load, and on `miso_out` one clock after a write made between words. An aborted word that leaves a stale count corrupts the very next full transfer.

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sclk_in,
  input  logic              mosi_in,
  input  logic              csn_in,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_done,
  output logic              tx_empty,
  output logic              miso_out,
  output logic              miso_oe
);
  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [2:0]        sck_sr;
  logic [1:0]        mosi_sr;
  logic [1:0]        csn_sr;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] rsh, sh, tx_buf, buf_ord, rx_next;
  logic              buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr  <= '0;
      mosi_sr <= '0;
      csn_sr  <= 2'b11;
    end else begin
      sck_sr  <= {sck_sr[1:0], sclk_in};
      mosi_sr <= {mosi_sr[0], mosi_in};
      csn_sr  <= {csn_sr[0], csn_in};
    end
  end

  wire cs_act  = ~csn_sr[1];
  wire sck_now = sck_sr[1] ^ cpol;
  wire sck_old = sck_sr[2] ^ cpol;
  wire lead    = sck_now & ~sck_old;
  wire trail   = ~sck_now & sck_old;
  wire tx_edge = cs_act & (cpha ? trail : lead);
  wire rx_edge = cs_act & (cpha ? lead : trail);
  wire idle    = (cnt == '0);

  always_comb begin
    for (int k = 0; k < WORD_W; k++)
      buf_ord[k] = lsb_first ? tx_buf[WORD_W-1-k] : tx_buf[k];
  end

  assign rx_next  = lsb_first ? {mosi_sr[1], rsh[WORD_W-1:1]}
                              : {rsh[WORD_W-2:0], mosi_sr[1]};
  assign miso_out = (idle && buf_full) ? buf_ord[WORD_W-1] : sh[WORD_W-1];
  assign miso_oe  = cs_act;
  assign tx_empty = ~buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rsh      <= '0;
      sh       <= '0;
      tx_buf   <= '0;
      buf_full <= 1'b0;
      rd_data  <= '0;
      rx_done  <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!cs_act) begin
        cnt <= '0;
      end else if (rx_edge) begin
        rsh <= rx_next;
        if (cnt == LAST) begin
          cnt     <= '0;
          rd_data <= rx_next;
          rx_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (idle)
          sh <= buf_full ? buf_ord : {WORD_W{sh[WORD_W-1]}};
      end else if (tx_edge && !idle) begin
        sh <= {sh[WORD_W-2:0], 1'b0};
      end
      if (wr_en) begin
        tx_buf   <= wr_data;
        buf_full <= 1'b1;
      end else if (rx_edge && idle) begin
        buf_full <= 1'b0;
      end
    end
  end

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idle && !rx_edge) |=> (miso_out == ($past(lsb_first) ? $past(wr_data[0]) : $past(wr_data[WORD_W-1])))); // R4
  AST_MID_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !idle && !tx_edge && !rx_edge) |=> $stable(miso_out)); // R5
  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !buf_full && !wr_en) |=> $stable(miso_out)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R7
  AST_EMPTY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_edge && idle && buf_full && !wr_en) |=> tx_empty); // R8
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !rx_done); // R9
endmodule

// File: tb/spi_os_slave_tb_top.sv
module spi_os_slave_tb_top;
  localparam int W = 16;
  localparam int H = 6;

  logic clk = 0, rst_n = 0;
  logic cpol = 0, cpha = 0, lsb_first = 0;
  logic sclk_in = 0, mosi_in = 0, csn_in = 1, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rx_done, tx_empty, miso_out, miso_oe;
  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_os_slave #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .sclk_in(sclk_in), .mosi_in(mosi_in), .csn_in(csn_in), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rx_done(rx_done), .tx_empty(tx_empty),
    .miso_out(miso_out), .miso_oe(miso_oe));

  always @(posedge clk) if (rst_n && rx_done) done_cnt++;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic mbit(input logic [W-1:0] w, input int i);
    return lsb_first ? w[i] : w[W-1-i];
  endfunction

  task automatic write_word(input logic [W-1:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic xfer(input logic [W-1:0] mw, input int nbits, output logic [W-1:0] got);
    got = '0;
    @(negedge clk); sclk_in = cpol; csn_in = 0; mosi_in = mbit(mw, 0);
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        if (i > 0) mosi_in = mbit(mw, i);
        sclk_in = ~cpol; wait_clk(H);
        got[lsb_first ? i : W-1-i] = miso_out;
        sclk_in = cpol; wait_clk(H);
      end else begin
        got[lsb_first ? i : W-1-i] = miso_out;
        sclk_in = ~cpol; wait_clk(H);
        sclk_in = cpol;
        if (i + 1 < W) mosi_in = mbit(mw, i + 1);
        wait_clk(H);
      end
    end
    wait_clk(6); csn_in = 1; wait_clk(4);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l);
    @(negedge clk); cpol = p; cpha = h; lsb_first = l; sclk_in = p;
    wait_clk(5);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, '0);
    chk("R1 rx_done", W'(rx_done), '0);
    chk("R1 tx_empty", W'(tx_empty), W'(1));
    chk("R1 miso_oe", W'(miso_oe), '0);
  endtask

  task automatic t_mode(input logic p, input logic h, input logic l,
                        input logic [W-1:0] txw, input logic [W-1:0] mw);
    logic [W-1:0] got;
    int d0;
    set_mode(p, h, l);
    write_word(txw);
    chk("R8 empty low after write", W'(tx_empty), '0);
    chk("R4 first bit visible", W'(miso_out), W'(l ? txw[0] : txw[W-1]));
    d0 = done_cnt;
    xfer(mw, W, got);
    chk("R2 R3 R5 slave to master word", got, txw);
    chk("R7 R3 received word", rd_data, mw);
    chk("R7 one done pulse", W'(done_cnt - d0), W'(1));
    chk("R8 empty after start", W'(tx_empty), W'(1));
  endtask

  task automatic t_hold_resend(input logic [W-1:0] txw);
    logic [W-1:0] got;
    logic fin;
    t_mode(1'b0, 1'b1, 1'b0, txw, 16'h1234);
    fin = txw[0];
    wait_clk(40);
    chk("R6 final bit held", W'(miso_out), W'(fin));
    xfer(16'h0F0F, W, got);
    chk("R6 resend final bit", got, {W{fin}});
    chk("R6 empty stays high", W'(tx_empty), W'(1));
  endtask

  task automatic t_abort;
    logic [W-1:0] got;
    int d0;
    set_mode(1'b0, 1'b0, 1'b0);
    write_word(16'hAAAA);
    d0 = done_cnt;
    xfer(16'hFFFF, 5, got);
    chk("R9 no done on abort", W'(done_cnt - d0), '0);
    chk("R9 oe low when deselected", W'(miso_oe), '0);
    write_word(16'h5A3C);
    xfer(16'hC3E1, W, got);
    chk("R9 fresh word sent", got, 16'h5A3C);
    chk("R9 fresh word received", rd_data, 16'hC3E1);
    chk("R9 single done after abort", W'(done_cnt - d0), W'(1));
  endtask

  initial begin
    wait_clk(3); rst_n = 1; wait_clk(3);
    t_reset();
    t_mode(1'b0, 1'b0, 1'b0, 16'hB4C1, 16'h3E96);
    t_mode(1'b0, 1'b1, 1'b1, 16'h8D27, 16'h71A5);
    t_mode(1'b1, 1'b0, 1'b1, 16'hE01B, 16'h4C3F);
    t_mode(1'b1, 1'b1, 1'b0, 16'h2F68, 16'h9ED0);
    t_mode(1'b0, 1'b0, 1'b1, 16'h0001, 16'h8000);
    t_hold_resend(16'h6AC3);
    t_hold_resend(16'h6AC2);
    t_abort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule